// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a two-stage programmable timer. A 24-bit divider counts qualified tick pulses. Each time the divider completes a period, a 32-bit main counter takes one step. The tick is a one-cycle enable on the system clock, so the block has no second clock domain. Two compare values watch the main counter. Each one can raise a status bit, and each can also force the main counter back to its start value. The start value is either the programmed load value or zero. In zero-based mode the counter runs from 0 up to one less than the load value and then wraps.

A stop mode makes the main counter freeze at its terminal value until software restarts the timer. One bit of the combined counter state can be chosen as an extra interrupt source, and it raises status on its rising edge. Software clears status in one of two ways, selected by a control bit: reading the status register, or writing ones to the bits it wants cleared. The interrupt pin is high while any status bit is set. A snapshot option makes the two counter readbacks coherent: a prescaler read also captures the main counter. Software reaches all of this through a simple synchronous register port with separate read and write strobes.

Top module: `match_timer`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x00007FFF. PCNT (4), MCNT (5) and IRQ (6) read 0, and irq_o is low.
- R2: While counting is enabled, each tick advances the divider from 0 up to CTRL[23:0] and then wraps it to 0. Each wrap advances the main counter by one.
- R3: A restart loads the divider with 0. It loads the main counter with START (address 1), or with 0 when CTRL[25] (zero base) is set. In zero-base mode the main counter steps from START−1 to 0.
- R4: With CTRL[26] (halt at end) set, a step taken at the terminal value (START−1 in zero-base mode, otherwise all ones) freezes both counters until the next restart.
- R5: A step taken while the main counter equals CMPA (address 2) reloads the start value when CTRL[27] is set. CMPB (address 3) does the same when CTRL[28] is set. The two controls are independent.
- R6: Writing CTRL or START restarts both counters one cycle after the write.
- R7: With CTRL[24] (enable) clear, ticks change neither counter.
- R8: IRQ[13:8] selects a source bit from {MCNT, PCNT}. Codes 0 to 23 pick PCNT bits and codes 24 to 55 pick MCNT bits 0 to 31. A rising edge of the selected bit sets status bit 2 (IRQ[2]).
- R9: A step taken at CMPA sets IRQ[0], and a step taken at CMPB sets IRQ[1]. irq_o is high while any status bit is set.
- R10: With IRQ[17] clear, a read of IRQ returns the status and then clears all status bits.
- R11: With IRQ[17] set, reads leave the status unchanged. A write to IRQ clears exactly the status bits written as one.
- R12: With IRQ[16] clear, a read of PCNT captures the main counter, and later MCNT reads return that capture. With IRQ[16] set, MCNT reads return the live value.
- R13: Bits above the defined fields read as zero. For example, writing all ones to CTRL reads back 0x1FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle count enable |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
Read data is registered, so each read result appears one cycle after its strobe. A monitor pops the expected word from the scoreboard queue at the falling edge after that cycle. A write to CTRL or START moves the counters one cycle after the write cycle, so the driver inserts one idle cycle before the next tick. Match status and irq_o update on the same edge as the counting step. A rising edge of a selected bit sets status one edge later, so the bench waits two idle cycles before it reads status. Direct checks of irq_o are sampled at falling edges, after the edge that caused the change.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  // register map (word addresses)
  localparam logic [2:0] RG_CTRL  = 3'd0;
  localparam logic [2:0] RG_START = 3'd1;
  localparam logic [2:0] RG_CMPA  = 3'd2;
  localparam logic [2:0] RG_CMPB  = 3'd3;
  localparam logic [2:0] RG_PCNT  = 3'd4;
  localparam logic [2:0] RG_MCNT  = 3'd5;
  localparam logic [2:0] RG_IRQ   = 3'd6;
  // status bit indices
  localparam int ST_A   = 0;
  localparam int ST_B   = 1;
  localparam int ST_SEL = 2;
  localparam int NST    = 3;
  // IRQ register field positions
  localparam int SEL_LSB  = 8;
  localparam int NOSYNC_B = 16;
  localparam int W1C_B    = 17;
endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler #(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step_en,
  input  logic [PW-1:0] div,
  output logic [PW-1:0] pcnt,
  output logic          wrap
);
  logic at_top;
  assign at_top = (pcnt == div);
  assign wrap   = step_en && at_top && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (step_en)   pcnt <= at_top ? '0 : pcnt + PW'(1);
  end
endmodule

// File: rtl/mtmr_main_cnt.sv
module mtmr_main_cnt #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  input  logic          zero_base,
  input  logic          oneshot,
  input  logic          rl_a,
  input  logic          rl_b,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  output logic [CW-1:0] mcnt,
  output logic          hit_a,
  output logic          hit_b,
  output logic          halted
);
  logic [CW-1:0] base, term;
  assign base  = zero_base ? '0 : start;
  assign term  = zero_base ? start - CW'(1) : '1;
  assign hit_a = step && (mcnt == cmp_a);
  assign hit_b = step && (mcnt == cmp_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt   <= '0;
      halted <= 1'b0;
    end else if (restart) begin
      mcnt   <= base;
      halted <= 1'b0;
    end else if (step) begin
      if ((hit_a && rl_a) || (hit_b && rl_b)) mcnt <= base;
      else if (mcnt == term) begin
        if (oneshot) halted <= 1'b1;
        else         mcnt   <= '0;
      end else mcnt <= mcnt + CW'(1);
    end
  end
endmodule

// File: rtl/mtmr_irq.sv
module mtmr_irq
  import mtmr_pkg::*;
#(
  parameter int PW   = 24,
  parameter int CW   = 32,
  parameter int SELW = $clog2(PW + CW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PW-1:0]   pcnt,
  input  logic [CW-1:0]   mcnt,
  input  logic [SELW-1:0] sel,
  input  logic            hit_a,
  input  logic            hit_b,
  input  logic [NST-1:0]  clr,
  output logic [NST-1:0]  status,
  output logic            irq
);
  localparam int NSRC = PW + CW;

  logic [NSRC-1:0] both;
  logic            src, src_q;
  logic [NST-1:0]  set, status_d;

  assign both = {mcnt, pcnt};

  always_comb begin
    src = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (int'(sel) == i) src = both[i];
  end

  always_comb begin
    set         = '0;
    set[ST_A]   = hit_a;
    set[ST_B]   = hit_b;
    set[ST_SEL] = src && !src_q;
    status_d    = (status & ~clr) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= 1'b0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      src_q  <= src;
      status <= status_d;
      irq    <= |status_d;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int PW        = 24,
  parameter int CW        = 32,
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int PRESC_RST = 32'h0000_7FFF
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int SELW  = $clog2(PW + CW);
  localparam int CTLW  = PW + 5;
  localparam int EN_B  = PW;
  localparam int ZB_B  = PW + 1;
  localparam int OS_B  = PW + 2;
  localparam int RLA_B = PW + 3;
  localparam int RLB_B = PW + 4;

  logic [CTLW-1:0] ctrl_q;
  logic [CW-1:0]   start_q, cmpa_q, cmpb_q, snap_q;
  logic [SELW-1:0] sel_q;
  logic            nosync_q, w1c_q, restart_q;
  logic [DW-1:0]   rdata_q, rd_mux;

  logic [PW-1:0]   pcnt;
  logic [CW-1:0]   mcnt;
  logic            wrap, halted, hit_a, hit_b, step_en, irq_wr, irq_rd;
  logic [NST-1:0]  status, clr_mask;

  assign step_en = ctrl_q[EN_B] && tick_i && !halted;
  assign irq_wr  = wr_i && (addr_i == AW'(RG_IRQ));
  assign irq_rd  = rd_i && (addr_i == AW'(RG_IRQ));

  always_comb begin
    if (irq_rd && !w1c_q)     clr_mask = '1;
    else if (irq_wr && w1c_q) clr_mask = wdata_i[NST-1:0];
    else                      clr_mask = '0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      AW'(RG_CTRL):  rd_mux = DW'(ctrl_q);
      AW'(RG_START): rd_mux = DW'(start_q);
      AW'(RG_CMPA):  rd_mux = DW'(cmpa_q);
      AW'(RG_CMPB):  rd_mux = DW'(cmpb_q);
      AW'(RG_PCNT):  rd_mux = DW'(pcnt);
      AW'(RG_MCNT):  rd_mux = nosync_q ? DW'(mcnt) : DW'(snap_q);
      AW'(RG_IRQ): begin
        rd_mux[NST-1:0]          = status;
        rd_mux[SEL_LSB +: SELW]  = sel_q;
        rd_mux[NOSYNC_B]         = nosync_q;
        rd_mux[W1C_B]            = w1c_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q    <= CTLW'(PRESC_RST);
      start_q   <= '0;
      cmpa_q    <= '0;
      cmpb_q    <= '0;
      snap_q    <= '0;
      sel_q     <= '0;
      nosync_q  <= 1'b0;
      w1c_q     <= 1'b0;
      restart_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      restart_q <= wr_i && ((addr_i == AW'(RG_CTRL)) || (addr_i == AW'(RG_START)));
      if (wr_i) begin
        case (addr_i)
          AW'(RG_CTRL):  ctrl_q  <= wdata_i[CTLW-1:0];
          AW'(RG_START): start_q <= wdata_i[CW-1:0];
          AW'(RG_CMPA):  cmpa_q  <= wdata_i[CW-1:0];
          AW'(RG_CMPB):  cmpb_q  <= wdata_i[CW-1:0];
          AW'(RG_IRQ): begin
            sel_q    <= wdata_i[SEL_LSB +: SELW];
            nosync_q <= wdata_i[NOSYNC_B];
            w1c_q    <= wdata_i[W1C_B];
          end
          default: ;
        endcase
      end
      if (rd_i && (addr_i == AW'(RG_PCNT))) snap_q <= mcnt;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;

  mtmr_prescaler #(.PW(PW)) u_pre (
    .clk(clk_i), .rst(rst_i), .restart(restart_q), .step_en(step_en),
    .div(ctrl_q[PW-1:0]), .pcnt(pcnt), .wrap(wrap)
  );

  mtmr_main_cnt #(.CW(CW)) u_main (
    .clk(clk_i), .rst(rst_i), .restart(restart_q), .step(wrap),
    .zero_base(ctrl_q[ZB_B]), .oneshot(ctrl_q[OS_B]),
    .rl_a(ctrl_q[RLA_B]), .rl_b(ctrl_q[RLB_B]),
    .start(start_q), .cmp_a(cmpa_q), .cmp_b(cmpb_q),
    .mcnt(mcnt), .hit_a(hit_a), .hit_b(hit_b), .halted(halted)
  );

  mtmr_irq #(.PW(PW), .CW(CW), .SELW(SELW)) u_irq (
    .clk(clk_i), .rst(rst_i), .pcnt(pcnt), .mcnt(mcnt), .sel(sel_q),
    .hit_a(hit_a), .hit_b(hit_b), .clr(clr_mask),
    .status(status), .irq(irq_o)
  );
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk #(
  parameter int PW = 24,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          restart,
  input logic          en,
  input logic          halted,
  input logic [PW-1:0] div,
  input logic [PW-1:0] pcnt,
  input logic [CW-1:0] mcnt,
  input logic          w1c,
  input logic          irq_wr,
  input logic [2:0]    status
);
  // R2: divider never passes its programmed top outside a restart
  a_r2_pcnt_in_range: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (pcnt <= div));

  // R6: a restart leaves the divider at zero
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pcnt == '0));

  // R7: disabled timer does not move its main counter
  a_r7_off_holds: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> $stable(mcnt));

  // R4: a halted timer keeps both counters frozen
  a_r4_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    (halted && !restart) |=> ($stable(mcnt) && $stable(pcnt)));

  // R11: in write-one-to-clear mode status bits only drop on a register write
  a_r11_w1c_sticky: assert property (@(posedge clk) disable iff (rst)
    (w1c && !irq_wr) |=> ((status & $past(status)) == $past(status)));
endmodule

bind match_timer mtmr_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk(clk_i), .rst(rst_i), .restart(restart_q), .en(ctrl_q[EN_B]),
  .halted(halted), .div(ctrl_q[PW-1:0]), .pcnt(pcnt), .mcnt(mcnt),
  .w1c(w1c_q), .irq_wr(irq_wr), .status(status)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sb[$];
  logic pend = 1'b0;

  always #2.5 clk = ~clk;

  match_timer u0 (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: read data is due one cycle after the strobe
  always @(posedge clk) pend <= rd;
  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read data %h", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.mask != 0) begin
          checks++;
          if ((rdata & it.mask) !== (it.exp & it.mask)) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, rdata & it.mask, it.exp & it.mask);
          end
        end
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [31:0] exp,
                        input logic [31:0] mask, input string tag);
    item_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb.push_back(it);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_counts(input logic [31:0] ep, input logic [31:0] em, input string tag);
    rd_reg(3'd4, ep, 32'hFFFF_FFFF, {tag, " pcnt"});
    rd_reg(3'd5, em, 32'hFFFF_FFFF, {tag, " mcnt"});
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    rd_reg(3'd0, 32'h0000_7FFF, 32'hFFFF_FFFF, "R1 ctrl reset");
    rd_counts(32'd0, 32'd0, "R1");
    rd_reg(3'd6, 32'd0, 32'hFFFF_FFFF, "R1 irq reg reset");

    // R2 R3 R6: non-zero base, divide by 3
    wr_reg(3'd1, 32'd10);
    wr_reg(3'd0, 32'h0100_0002);
    rd_counts(32'd0, 32'd10, "R6 restart loads start");
    ticks(7);
    rd_counts(32'd1, 32'd12, "R2 prescaled count");

    // R3 zero-base wrap at START-1
    wr_reg(3'd0, 32'h0300_0000);
    wr_reg(3'd1, 32'd3);
    rd_counts(32'd0, 32'd0, "R3 zero base load");
    ticks(4);
    rd_counts(32'd0, 32'd1, "R3 zero base wrap");

    // R4 halt at end, zero base
    wr_reg(3'd0, 32'h0700_0000);
    ticks(5);
    rd_counts(32'd0, 32'd2, "R4 halt zero base");
    // R4 halt at all ones
    wr_reg(3'd1, 32'hFFFF_FFFE);
    wr_reg(3'd0, 32'h0500_0000);
    ticks(3);
    rd_counts(32'd0, 32'hFFFF_FFFF, "R4 halt all ones");

    // R5 R9 R10: reload on A only, both set status
    wr_reg(3'd2, 32'd5);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd1, 32'd2);
    wr_reg(3'd0, 32'h0900_0000);
    rd_reg(3'd6, 32'd0, 32'd0, "clear");
    chk({31'd0, irq}, 32'd0, "R10 irq low after clear read");
    ticks(6);
    rd_counts(32'd0, 32'd4, "R5 reload on A not B");
    chk({31'd0, irq}, 32'd1, "R9 irq high with status");
    rd_reg(3'd6, 32'h0000_0003, 32'hFFFF_FFFF, "R9 match status");
    chk({31'd0, irq}, 32'd0, "R10 read clears irq");
    rd_reg(3'd6, 32'h0000_0000, 32'hFFFF_FFFF, "R10 status cleared");

    // R11 write-one-to-clear mode
    wr_reg(3'd6, 32'h0002_0000);
    ticks(4);
    rd_reg(3'd6, 32'h0002_0003, 32'hFFFF_FFFF, "R11 status set");
    rd_reg(3'd6, 32'h0002_0003, 32'hFFFF_FFFF, "R11 read keeps status");
    wr_reg(3'd6, 32'h0002_0001);
    rd_reg(3'd6, 32'h0002_0002, 32'hFFFF_FFFF, "R11 write clears one bit");
    chk({31'd0, irq}, 32'd1, "R11 irq still high");

    // R8 select MCNT bit 1 (code 25)
    wr_reg(3'd0, 32'h0100_0000);
    wr_reg(3'd1, 32'd0);
    wr_reg(3'd6, 32'h0002_1907);
    chk({31'd0, irq}, 32'd0, "R11 all cleared");
    ticks(2);
    repeat (2) @(negedge clk);
    rd_reg(3'd6, 32'h0002_1904, 32'hFFFF_FFFF, "R8 selected bit edge");

    // R12 snapshot behaviour
    rd_reg(3'd4, 32'd0, 32'hFFFF_FFFF, "R12 pcnt capture");
    ticks(1);
    rd_reg(3'd5, 32'd2, 32'hFFFF_FFFF, "R12 mcnt from snapshot");
    wr_reg(3'd6, 32'h0003_1900);
    rd_reg(3'd5, 32'd3, 32'hFFFF_FFFF, "R12 mcnt live");

    // R7 disabled, R6 restart via START
    wr_reg(3'd0, 32'h0000_0000);
    ticks(3);
    rd_reg(3'd5, 32'd0, 32'hFFFF_FFFF, "R7 disabled holds");
    rd_reg(3'd4, 32'd0, 32'hFFFF_FFFF, "R7 divider holds");
    wr_reg(3'd1, 32'd7);
    rd_reg(3'd5, 32'd7, 32'hFFFF_FFFF, "R6 start write restarts");

    // R13 reserved bits
    wr_reg(3'd0, 32'hFFFF_FFFF);
    rd_reg(3'd0, 32'h1FFF_FFFF, 32'hFFFF_FFFF, "R13 ctrl reserved zero");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule